// File: doc/BRIEF.md
# Per-Thread Squash Request Controller

This block decides, for every hardware thread of an out-of-order retirement stage, which squash request is acted on in a given cycle and drives the resulting squash broadcast back to the earlier pipeline stages. There are three request sources:

- a trap request that becomes pending a programmable number of cycles after a trap is raised;
- an externally requested whole-thread squash;
- an execute-stage squash that carries a sequence number, an include-self flag, a redirect PC and branch outcome information.

A whole-thread squash takes its squash point from the head of the reorder buffer. An execute-stage squash takes its squash point from the sequence number it carries.

Each thread keeps a record of its youngest valid sequence number. An execute-stage squash for an instruction younger than that record is refused, so a late squash from a younger instruction cannot override an earlier one from an older instruction. Once a squash is accepted, the thread enters a squashing state and keeps signalling it until the reorder buffer reports that it has finished. While a thread is in that state, instructions arriving from rename for it are dropped.

When a trap request and an external request are pending together, the trap request is served first. The external request is served one cycle later.

Top module: `commit_squash_ctl`

## Requirements
- R1: After reset every thread is Running (`thr_state` = 0), and `sq_valid`, `sq_rob_busy`, `sq_mispredict` and `mispred_count` are all zero.
- R2: A `trap_raise` seen while a thread is Running moves it to TrapPending (`thr_state` = 1). Its whole-thread squash broadcast appears at the (D+2)-th rising edge after the edge that sampled the raise, where D is `trap_delay`.
- R3: A whole-thread squash (trap or external) reports `sq_done_seq` = head sequence minus one, or 0 when `rob_empty` is set. It redirects to `thread_pc` with `sq_mispredict` and `sq_taken` at 0, and it resets the youngest sequence number to 0.
- R4: An execute-stage squash is accepted only when its sequence number is less than or equal to the thread's youngest sequence number; otherwise `sq_valid` stays 0.
- R5: With `ex_incl_self` = 1 the squash point is the given sequence number minus one, otherwise the number itself. The youngest sequence number becomes the squash point.
- R6: An accepted execute-stage squash raises `sq_valid` and `sq_rob_busy` for one cycle after the sampling edge. It forwards `ex_next_pc`, `ex_mispred_pc`, `ex_taken` and `ex_mispredict`; `sq_mispredict` is never set without `sq_valid`.
- R7: After any accepted squash the thread is in the squashing state (`thr_state` = 2). It keeps `sq_rob_busy` at 1 each cycle until an edge samples `rob_sq_done` = 1, after which it returns to Running with `sq_rob_busy` = 0.
- R8: While a thread is TrapPending, execute-stage squashes for it are ignored.
- R9: A rename arrival is accepted (`rn_accept` = 1) and updates the youngest sequence number only when the thread is not squashing and `rn_squashed` = 0.
- R10: `mispred_count` increases by the number of threads that accept an execute-stage squash with `ex_mispredict` = 1 at that edge.
- R11: At most one source is served per thread per cycle. A pending whole-thread squash wins over an execute-stage squash in the same cycle; the execute-stage squash is dropped and the pending flag is cleared when it is served.
- R12: Threads are independent: a squash on one thread leaves the other threads' squash outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_raise | input | NT | Per-thread trap raise pulse |
| trap_delay | input | DLY_W | Cycles between a trap raise and its pending request |
| ctx_squash_req | input | NT | Per-thread external whole-thread squash request pulse |
| ex_valid | input | NT | Execute-stage squash present |
| ex_seq | input | NT*SEQ_W | Execute-stage squash sequence number |
| ex_incl_self | input | NT | Squash the named instruction as well |
| ex_next_pc | input | NT*PC_W | Redirect PC from execute |
| ex_mispred_pc | input | NT*PC_W | PC of the mispredicted instruction |
| ex_taken | input | NT | Branch taken flag |
| ex_mispredict | input | NT | Branch mispredict flag |
| rob_head_seq | input | NT*SEQ_W | Sequence number at reorder buffer head |
| rob_empty | input | NT | Reorder buffer holds nothing for the thread |
| rob_sq_done | input | NT | Reorder buffer has finished squashing |
| thread_pc | input | NT*PC_W | Current architectural PC of the thread |
| rn_valid | input | NT | Instruction arriving from rename |
| rn_seq | input | NT*SEQ_W | Its sequence number |
| rn_squashed | input | NT | Arriving instruction already marked squashed |
| sq_valid | output | NT | Squash broadcast |
| sq_rob_busy | output | NT | Reorder buffer squashing in progress |
| sq_done_seq | output | NT*SEQ_W | Squash point sequence number |
| sq_redirect_pc | output | NT*PC_W | Redirect PC |
| sq_mispred_pc | output | NT*PC_W | Forwarded mispredict PC |
| sq_taken | output | NT | Forwarded branch taken flag |
| sq_mispredict | output | NT | Forwarded mispredict flag |
| thr_state | output | NT*2 | Thread state: 0 Running, 1 TrapPending, 2 squashing |
| rn_accept | output | NT | Rename arrival accepted |
| mispred_count | output | CNT_W | Accepted mispredict squashes |

## Verification
The collision that matters is a whole-thread squash and an execute-stage squash falling on the same thread in the same cycle. It is provoked by pulsing the external request one cycle before an execute-stage squash that would otherwise be accepted. The outcome is judged on three points: the broadcast carries the head-derived squash point with the mispredict flag at 0, the mispredict count does not move, and no squash follows in the next cycle. A second overlap, a trap raise pending while an execute-stage squash arrives, is judged by the absence of any broadcast until the trap delay has run out.

// File: rtl/csq_pkg.sv
// Shared types for the per-thread squash controller.
// Assumes: the state encoding is visible at the top-level ports.
package csq_pkg;
    typedef enum logic [1:0] {
        TS_RUN   = 2'd0,
        TS_TRAP  = 2'd1,
        TS_ROBSQ = 2'd2
    } thr_state_e;
endpackage

// File: rtl/csq_trap_timer.sv
// Trap delay timer: after start, counts the programmed delay down to zero
// and then raises a sticky pending flag until the owner clears it.
// Assumes: start is never issued while armed or pending.
module csq_trap_timer #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] delay,
    input  logic             clr,
    output logic             pend
);
    logic             armed_q;
    logic [DLY_W-1:0] cnt_q;

    // Count down while armed, convert expiry into a pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            pend    <= 1'b0;
        end else begin
            if (start) begin
                armed_q <= 1'b1;
                cnt_q   <= delay;
            end else if (armed_q && cnt_q == '0) begin
                armed_q <= 1'b0;
            end else if (armed_q) begin
                cnt_q <= cnt_q - DLY_W'(1);
            end
            if (armed_q && cnt_q == '0 && !start)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/csq_thread.sv
// One thread's squash arbitration: serves at most one of trap, external or
// execute-stage squash per cycle, tracks the youngest sequence number and
// drives the registered squash broadcast and thread state.
// Assumes: sequence numbers grow monotonically within a thread.
module csq_thread
    import csq_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_raise,
    input  logic [DLY_W-1:0] trap_delay,
    input  logic             ctx_req,
    input  logic             ex_valid,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic [PC_W-1:0]  ex_next_pc,
    input  logic [PC_W-1:0]  ex_mpc,
    input  logic             ex_taken,
    input  logic             ex_mispredict,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             rob_empty,
    input  logic             rob_done,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic             rn_valid,
    input  logic [SEQ_W-1:0] rn_seq,
    input  logic             rn_squashed,
    output logic             sq_valid,
    output logic             rob_busy,
    output logic [SEQ_W-1:0] done_seq,
    output logic [PC_W-1:0]  redir_pc,
    output logic [PC_W-1:0]  mpc_o,
    output logic             taken_o,
    output logic             mispredict_o,
    output thr_state_e       state_o,
    output logic             rn_accept,
    output logic             mispred_evt
);
    thr_state_e       state_q;
    logic             ctx_q;
    logic             trap_pend;
    logic [SEQ_W-1:0] young_q;
    logic             full_sq, raise_ok, ex_ok;
    logic [SEQ_W-1:0] sq_point;

    csq_trap_timer #(.DLY_W(DLY_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (raise_ok),
        .delay (trap_delay),
        .clr   (trap_pend),
        .pend  (trap_pend)
    );

    // Pick the single source served this cycle and its squash point.
    always_comb begin
        full_sq  = trap_pend | ctx_q;
        raise_ok = !full_sq && trap_raise && state_q == TS_RUN;
        ex_ok    = !full_sq && !raise_ok && ex_valid &&
                   state_q != TS_TRAP && ex_seq <= young_q;
        if (full_sq)
            sq_point = rob_empty ? '0 : head_seq - SEQ_W'(1);
        else
            sq_point = ex_incl ? ex_seq - SEQ_W'(1) : ex_seq;
        rn_accept   = rn_valid && !rn_squashed && state_q != TS_ROBSQ &&
                      !full_sq && !ex_ok;
        mispred_evt = ex_ok && ex_mispredict;
    end

    // External request flag: kept while a trap is served first.
    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= 1'b0;
        else        ctx_q <= (ctx_q && trap_pend) || ctx_req;
    end

    // Thread state and youngest sequence tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_RUN;
            young_q <= '0;
        end else begin
            if (full_sq)                             state_q <= TS_ROBSQ;
            else if (raise_ok)                       state_q <= TS_TRAP;
            else if (ex_ok)                          state_q <= TS_ROBSQ;
            else if (state_q == TS_ROBSQ && rob_done) state_q <= TS_RUN;
            if (full_sq)        young_q <= '0;
            else if (ex_ok)     young_q <= sq_point;
            else if (rn_accept) young_q <= rn_seq;
        end
    end

    // Registered squash broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid     <= 1'b0;
            rob_busy     <= 1'b0;
            done_seq     <= '0;
            redir_pc     <= '0;
            mpc_o        <= '0;
            taken_o      <= 1'b0;
            mispredict_o <= 1'b0;
        end else begin
            sq_valid     <= full_sq || ex_ok;
            rob_busy     <= full_sq || ex_ok || (state_q == TS_ROBSQ && !rob_done);
            taken_o      <= ex_ok && ex_taken;
            mispredict_o <= ex_ok && ex_mispredict;
            if (full_sq || ex_ok) done_seq <= sq_point;
            if (full_sq)          redir_pc <= cur_pc;
            else if (ex_ok)       redir_pc <= ex_next_pc;
            if (ex_ok)            mpc_o    <= ex_mpc;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/csq_event_counter.sv
// Wrapping counter that adds the number of set bits of an event vector
// on each clock. Assumes: CNT_W can hold at least N.
module csq_event_counter #(
    parameter int N     = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     evt,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] inc;

    // Population count of this cycle's events.
    always_comb begin
        inc = '0;
        for (int i = 0; i < N; i++) inc = inc + CNT_W'(evt[i]);
    end

    // Accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + inc;
    end
endmodule

// File: rtl/commit_squash_ctl.sv
// Top: one squash arbiter per thread plus a shared mispredict counter.
// Assumes: per-thread inputs are packed with thread 0 in the low slice.
module commit_squash_ctl
    import csq_pkg::*;
#(
    parameter int NT    = 2,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int DLY_W = 6,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NT-1:0]             trap_raise,
    input  logic [DLY_W-1:0]          trap_delay,
    input  logic [NT-1:0]             ctx_squash_req,
    input  logic [NT-1:0]             ex_valid,
    input  logic [NT-1:0][SEQ_W-1:0]  ex_seq,
    input  logic [NT-1:0]             ex_incl_self,
    input  logic [NT-1:0][PC_W-1:0]   ex_next_pc,
    input  logic [NT-1:0][PC_W-1:0]   ex_mispred_pc,
    input  logic [NT-1:0]             ex_taken,
    input  logic [NT-1:0]             ex_mispredict,
    input  logic [NT-1:0][SEQ_W-1:0]  rob_head_seq,
    input  logic [NT-1:0]             rob_empty,
    input  logic [NT-1:0]             rob_sq_done,
    input  logic [NT-1:0][PC_W-1:0]   thread_pc,
    input  logic [NT-1:0]             rn_valid,
    input  logic [NT-1:0][SEQ_W-1:0]  rn_seq,
    input  logic [NT-1:0]             rn_squashed,
    output logic [NT-1:0]             sq_valid,
    output logic [NT-1:0]             sq_rob_busy,
    output logic [NT-1:0][SEQ_W-1:0]  sq_done_seq,
    output logic [NT-1:0][PC_W-1:0]   sq_redirect_pc,
    output logic [NT-1:0][PC_W-1:0]   sq_mispred_pc,
    output logic [NT-1:0]             sq_taken,
    output logic [NT-1:0]             sq_mispredict,
    output logic [NT-1:0][1:0]        thr_state,
    output logic [NT-1:0]             rn_accept,
    output logic [CNT_W-1:0]          mispred_count
);
    logic [NT-1:0] mp_evt;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        thr_state_e st;
        csq_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .DLY_W(DLY_W)) thr_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .trap_raise    (trap_raise[t]),
            .trap_delay    (trap_delay),
            .ctx_req       (ctx_squash_req[t]),
            .ex_valid      (ex_valid[t]),
            .ex_seq        (ex_seq[t]),
            .ex_incl       (ex_incl_self[t]),
            .ex_next_pc    (ex_next_pc[t]),
            .ex_mpc        (ex_mispred_pc[t]),
            .ex_taken      (ex_taken[t]),
            .ex_mispredict (ex_mispredict[t]),
            .head_seq      (rob_head_seq[t]),
            .rob_empty     (rob_empty[t]),
            .rob_done      (rob_sq_done[t]),
            .cur_pc        (thread_pc[t]),
            .rn_valid      (rn_valid[t]),
            .rn_seq        (rn_seq[t]),
            .rn_squashed   (rn_squashed[t]),
            .sq_valid      (sq_valid[t]),
            .rob_busy      (sq_rob_busy[t]),
            .done_seq      (sq_done_seq[t]),
            .redir_pc      (sq_redirect_pc[t]),
            .mpc_o         (sq_mispred_pc[t]),
            .taken_o       (sq_taken[t]),
            .mispredict_o  (sq_mispredict[t]),
            .state_o       (st),
            .rn_accept     (rn_accept[t]),
            .mispred_evt   (mp_evt[t])
        );
        assign thr_state[t] = st;
    end

    csq_event_counter #(.N(NT), .CNT_W(CNT_W)) mpcnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (mp_evt),
        .count (mispred_count)
    );
endmodule

// File: rtl/commit_squash_ctl_chk.sv
// Assertion checker bound to the squash controller top.
// Assumes: only port-level signals are observed.
module commit_squash_ctl_chk #(
    parameter int NT    = 2,
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NT-1:0]      sq_valid,
    input logic [NT-1:0]      sq_rob_busy,
    input logic [NT-1:0]      sq_mispredict,
    input logic [NT-1:0][1:0] thr_state,
    input logic [NT-1:0]      rob_sq_done,
    input logic [NT-1:0]      rn_accept,
    input logic [CNT_W-1:0]   mispred_count
);
    logic seen_q;

    // Marks that one edge has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> mispred_count == $past(mispred_count) + CNT_W'($countones(sq_mispredict))); // R10

    for (genvar t = 0; t < NT; t++) begin : g_chk
        AST_SQ_HAS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            sq_valid[t] |-> sq_rob_busy[t]); // R6
        AST_MP_HAS_SQ: assert property (@(posedge clk) disable iff (!rst_n)
            sq_mispredict[t] |-> sq_valid[t]); // R6
        AST_BUSY_IS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            sq_rob_busy[t] == (thr_state[t] == 2'd2)); // R7
        AST_HOLD_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 2'd2 && !rob_sq_done[t]) |=> sq_rob_busy[t]); // R7
        AST_TRAP_NO_EX: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 2'd1) |=> !sq_mispredict[t]); // R8
        AST_RN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 2'd2) |-> !rn_accept[t]); // R9
    end
endmodule

bind commit_squash_ctl commit_squash_ctl_chk #(.NT(NT), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sq_valid      (sq_valid),
    .sq_rob_busy   (sq_rob_busy),
    .sq_mispredict (sq_mispredict),
    .thr_state     (thr_state),
    .rob_sq_done   (rob_sq_done),
    .rn_accept     (rn_accept),
    .mispred_count (mispred_count)
);

// File: tb/commit_squash_ctl_tb_top.sv
// Directed bench for the squash controller.
module commit_squash_ctl_tb_top;
    localparam int NT = 2, SEQ_W = 16, PC_W = 32, DLY_W = 6, CNT_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NT-1:0]            trap_raise = '0, ctx_squash_req = '0, ex_valid = '0;
    logic [DLY_W-1:0]         trap_delay = '0;
    logic [NT-1:0][SEQ_W-1:0] ex_seq = '0, rob_head_seq = '0, rn_seq = '0;
    logic [NT-1:0]            ex_incl_self = '0, ex_taken = '0, ex_mispredict = '0;
    logic [NT-1:0][PC_W-1:0]  ex_next_pc = '0, ex_mispred_pc = '0, thread_pc = '0;
    logic [NT-1:0]            rob_empty = '0, rob_sq_done = '1, rn_valid = '0, rn_squashed = '0;
    logic [NT-1:0]            sq_valid, sq_rob_busy, sq_taken, sq_mispredict, rn_accept;
    logic [NT-1:0][SEQ_W-1:0] sq_done_seq;
    logic [NT-1:0][PC_W-1:0]  sq_redirect_pc, sq_mispred_pc;
    logic [NT-1:0][1:0]       thr_state;
    logic [CNT_W-1:0]         mispred_count;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    commit_squash_ctl #(.NT(NT), .SEQ_W(SEQ_W), .PC_W(PC_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) dut_i (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ex_squash(input int t, input int seq, input bit incl, input bit mp, input bit tk,
                             input int npc, input int mpc);
        ex_valid[t] = 1'b1; ex_seq[t] = SEQ_W'(seq); ex_incl_self[t] = incl;
        ex_mispredict[t] = mp; ex_taken[t] = tk;
        ex_next_pc[t] = PC_W'(npc); ex_mispred_pc[t] = PC_W'(mpc);
        tick();
        ex_valid[t] = 1'b0; ex_mispredict[t] = 1'b0; ex_taken[t] = 1'b0; ex_incl_self[t] = 1'b0;
    endtask

    task automatic rename(input int t, input int seq, input bit sqd, input bit exp_acc, input string req);
        rn_valid[t] = 1'b1; rn_seq[t] = SEQ_W'(seq); rn_squashed[t] = sqd;
        #1 chk(req, "rn_accept", 64'(rn_accept[t]), 64'(exp_acc));
        tick();
        rn_valid[t] = 1'b0; rn_squashed[t] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "sq_valid", 64'(sq_valid), 0);
        chk("R1", "sq_rob_busy", 64'(sq_rob_busy), 0);
        chk("R1", "thr_state", 64'(thr_state), 0);
        chk("R1", "mispred_count", 64'(mispred_count), 0);
    endtask

    task automatic t_exec_basic();
        rename(0, 5, 1'b0, 1'b1, "R9");
        rename(0, 6, 1'b1, 1'b0, "R9");
        ex_squash(0, 6, 0, 1, 1, 'h40, 'h3c);
        chk("R4", "younger rejected", 64'(sq_valid[0]), 0);
        rob_sq_done[0] = 1'b0;
        ex_squash(0, 5, 0, 1, 1, 'h40, 'h3c);
        chk("R4", "equal accepted", 64'(sq_valid[0]), 1);
        chk("R6", "busy", 64'(sq_rob_busy[0]), 1);
        chk("R6", "done_seq", 64'(sq_done_seq[0]), 5);
        chk("R6", "redirect", 64'(sq_redirect_pc[0]), 'h40);
        chk("R6", "mispred pc", 64'(sq_mispred_pc[0]), 'h3c);
        chk("R6", "mispredict/taken", {sq_mispredict[0], sq_taken[0]}, 2'b11);
        chk("R10", "count", 64'(mispred_count), 1);
        chk("R7", "state squashing", 64'(thr_state[0]), 2);
    endtask

    task automatic t_hold();
        rename(0, 9, 1'b0, 1'b0, "R9");
        chk("R7", "busy held", 64'(sq_rob_busy[0]), 1);
        chk("R6", "one-cycle pulse", 64'(sq_valid[0]), 0);
        tick();
        chk("R7", "busy still", 64'(sq_rob_busy[0]), 1);
        rob_sq_done[0] = 1'b1;
        tick();
        chk("R7", "busy dropped", 64'(sq_rob_busy[0]), 0);
        chk("R7", "back to running", 64'(thr_state[0]), 0);
    endtask

    task automatic t_include();
        ex_squash(0, 5, 1, 0, 0, 'h50, 0);
        chk("R5", "incl point", 64'(sq_done_seq[0]), 4);
        chk("R10", "no mp no count", 64'(mispred_count), 1);
        tick();
        ex_squash(0, 5, 0, 0, 0, 'h50, 0);
        chk("R5", "youngest lowered", 64'(sq_valid[0]), 0);
        ex_squash(0, 4, 0, 0, 0, 'h58, 0);
        chk("R5", "at new youngest", 64'(sq_done_seq[0]), 4);
        tick();
    endtask

    task automatic t_ctx();
        rob_head_seq[0] = 20; thread_pc[0] = 'h123;
        ctx_squash_req[0] = 1'b1; tick(); ctx_squash_req[0] = 1'b0;
        tick();
        chk("R3", "valid", 64'(sq_valid[0]), 1);
        chk("R3", "done_seq", 64'(sq_done_seq[0]), 19);
        chk("R3", "redirect", 64'(sq_redirect_pc[0]), 'h123);
        chk("R3", "mispredict", 64'(sq_mispredict[0]), 0);
        tick();
        ex_squash(0, 1, 0, 0, 0, 0, 0);
        chk("R3", "youngest zeroed", 64'(sq_valid[0]), 0);
        rob_empty[0] = 1'b1;
        ctx_squash_req[0] = 1'b1; tick(); ctx_squash_req[0] = 1'b0;
        tick();
        chk("R3", "empty done_seq", 64'(sq_done_seq[0]), 0);
        rob_empty[0] = 1'b0;
        tick();
    endtask

    task automatic t_same_cycle();
        rename(0, 30, 1'b0, 1'b1, "R9");
        ctx_squash_req[0] = 1'b1; tick(); ctx_squash_req[0] = 1'b0;
        ex_squash(0, 10, 0, 1, 1, 'h99, 'h98);
        chk("R11", "full wins seq", 64'(sq_done_seq[0]), 19);
        chk("R11", "full wins mp", 64'(sq_mispredict[0]), 0);
        chk("R11", "count unchanged", 64'(mispred_count), 1);
        tick();
        chk("R11", "no retry", 64'(sq_valid[0]), 0);
    endtask

    task automatic t_trap();
        int n;
        rename(0, 8, 1'b0, 1'b1, "R9");
        trap_delay = 3;
        trap_raise[0] = 1'b1; tick(); trap_raise[0] = 1'b0;
        chk("R2", "trap pending", 64'(thr_state[0]), 1);
        ex_squash(0, 2, 0, 1, 0, 'h10, 'h0c);
        chk("R8", "ex ignored", 64'(sq_valid[0]), 0);
        chk("R8", "still pending", 64'(thr_state[0]), 1);
        n = 1;
        while (!sq_valid[0] && n < 20) begin tick(); n++; end
        chk("R2", "edges to broadcast", 64'(n), 5);
        chk("R3", "trap done_seq", 64'(sq_done_seq[0]), 19);
        chk("R3", "trap mispredict", 64'(sq_mispredict[0]), 0);
        chk("R10", "count", 64'(mispred_count), 1);
        tick();
    endtask

    task automatic t_threads();
        ex_valid = '1; ex_seq = '0; ex_mispredict = '1;
        ex_next_pc[0] = 'h70; ex_next_pc[1] = 'h71;
        tick();
        ex_valid = '0; ex_mispredict = '0;
        chk("R10", "two at once", 64'(mispred_count), 3);
        chk("R12", "t1 redirect", 64'(sq_redirect_pc[1]), 'h71);
        tick();
        ex_squash(1, 0, 0, 0, 0, 'h99, 0);
        chk("R12", "t1 valid", 64'(sq_valid[1]), 1);
        chk("R12", "t0 quiet", 64'(sq_valid[0]), 0);
        chk("R12", "t0 pc kept", 64'(sq_redirect_pc[0]), 'h70);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_exec_basic();
        t_hold();
        t_include();
        t_ctx();
        t_same_cycle();
        t_trap();
        t_threads();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule